// File: doc/BRIEF.md
# ADC Recalibration Sequencer

This block sits next to a pipelined analog-to-digital converter and controls when that converter recalibrates itself. A recalibration is started by pulling the converter's active-low reset line low for a programmable number of controller clock cycles. The block counts that pulse in its own clock domain, because the converter's output clock stops while its reset is low. Recalibration is started in three cases: automatically once after the controller leaves reset, on a one-cycle software request, and when the measured sample-clock period drifts by more than one tenth from the period captured at the last successful calibration.

The converter raises its over-range flag as soon as its reset is pulled low, and it lowers the flag when calibration completes. The block starts its time origin at the rising edge of the reset line. It synchronises the flag and takes the flag's falling edge as the completion event. If the analog input is over range, the flag never falls, so a timeout counter ends the attempt. Requests that arrive while a calibration is running are merged into a single follow-up calibration. Status is shown as busy, done and timeout levels, plus a drift indication.

Top module: `adc_cal_sequencer`

## Requirements
- R1: While `rst_n` is low, `adc_rst_n` is 1 and `cal_busy`, `cal_done` and `cal_timeout` are 0.
- R2: After `rst_n` is released, one calibration starts without any request: `adc_rst_n` goes low within three cycles.
- R3: Every calibration drives `adc_rst_n` low for exactly `RST_PULSE_CYC` consecutive clock cycles.
- R4: `cal_busy` is 1 from the start of the pulse until completion or timeout. `cal_done` rises exactly three clock edges after the first edge that samples `adc_ovr` low (two synchroniser stages and one state register), and never earlier. At most one of busy, done and timeout is 1.
- R5: If the over-range flag does not fall, `cal_timeout` rises exactly `TIMEOUT_CYC` clock edges after the edge on which `adc_rst_n` returns to 1, and `cal_busy` drops.
- R6: A `cal_req` pulse while the block is idle starts a calibration on the next edge. Starting a calibration clears `cal_done` and `cal_timeout`.
- R7: Any number of `cal_req` pulses during a running calibration cause exactly one further calibration, which starts after the running one ends.
- R8: The reference period is taken from `clk_period` only when a calibration completes with the flag falling and `period_valid` is 1. A timeout leaves the reference unchanged.
- R9: `drift_flag` is 1 exactly when a reference exists, `period_valid` is 1 and 10·|clk_period − reference| > reference. A deviation of exactly one tenth does not count as drift.
- R10: While idle, an active drift condition starts a calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| cal_req | input | 1 | One-cycle software recalibration request |
| clk_period | input | PERIOD_W | Measured sample-clock period estimate |
| period_valid | input | 1 | `clk_period` holds a valid estimate |
| adc_ovr | input | 1 | Converter over-range flag, asynchronous |
| adc_rst_n | output | 1 | Active-low reset line to the converter |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Last calibration completed normally |
| cal_timeout | output | 1 | Last calibration ended by timeout |
| drift_flag | output | 1 | Sample-clock period outside the ±10 % band |

## Verification
The bench targets the exact drift boundary (a period 10 % above or below the reference must not trigger, one unit more must trigger). A design using a coarse shift approximation of one tenth would either recalibrate spuriously or miss real drift. It pins the completion latency and the timeout window to single cycles, which exposes a missing synchroniser stage, a timer that restarts when the flag rises, or an off-by-one limit. It checks that a burst of requests during a calibration produces exactly one follow-up pulse rather than none or several. It also checks that a timeout leaves the old reference in place, which a design that captures the period on every exit from calibration would fail.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [2:0] {
    CAL_IDLE,
    CAL_PULSE,
    CAL_ARM,
    CAL_WAIT,
    CAL_OK,
    CAL_EXPIRED
  } cal_state_t;

  // True when |cur - base| is strictly more than base/10, evaluated as 10*d > base
  function automatic logic drift_exceeds(input logic [31:0] base, input logic [31:0] cur);
    logic [31:0] d;
    logic [35:0] d10;
    d   = (cur >= base) ? (cur - base) : (base - cur);
    d10 = ({4'b0, d} << 3) + ({4'b0, d} << 1);
    return d10 > {4'b0, base};
  endfunction

endpackage

// File: rtl/adc_cal_sync.sv
module adc_cal_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic fell
);
  logic [1:0] sr;
  logic       lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= 2'b00;
      lvl_d <= 1'b0;
    end else begin
      sr    <= {sr[0], async_in};
      lvl_d <= sr[1];
    end
  end

  assign level = sr[1];
  assign fell  = lvl_d & ~sr[1];
endmodule

// File: rtl/adc_cal_timer.sv
module adc_cal_timer #(
  parameter int W     = 8,
  parameter int LIMIT = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] SAT = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (clr)          count <= '0;
    else if (count != SAT) count <= count + 1'b1;
  end
endmodule

// File: rtl/adc_cal_drift.sv
module adc_cal_drift import adc_cal_pkg::*; #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [PERIOD_W-1:0] period,
  input  logic                period_valid,
  output logic                drift
);
  logic [PERIOD_W-1:0] ref_q;
  logic                ref_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q       <= '0;
      ref_valid_q <= 1'b0;
    end else if (capture && period_valid) begin
      ref_q       <= period;
      ref_valid_q <= 1'b1;
    end
  end

  assign drift = ref_valid_q & period_valid & drift_exceeds(32'(ref_q), 32'(period));

  p_equal_no_drift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_valid && period == ref_q) |-> !drift);
  p_no_ref_no_drift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid_q |-> !drift);
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer import adc_cal_pkg::*; #(
  parameter int PERIOD_W      = 16,
  parameter int RST_PULSE_CYC = 4,
  parameter int TIMEOUT_CYC   = 100_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_req,
  input  logic [PERIOD_W-1:0] clk_period,
  input  logic                period_valid,
  input  logic                adc_ovr,
  output logic                adc_rst_n,
  output logic                cal_busy,
  output logic                cal_done,
  output logic                cal_timeout,
  output logic                drift_flag
);
  localparam int CNT_MAX = (TIMEOUT_CYC > RST_PULSE_CYC) ? TIMEOUT_CYC : RST_PULSE_CYC;
  localparam int TMR_W   = $clog2(CNT_MAX + 1);
  localparam logic [TMR_W-1:0] PULSE_LAST = TMR_W'(RST_PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] WAIT_LAST  = TMR_W'(TIMEOUT_CYC - 1);
  localparam int LOW_W = $clog2(RST_PULSE_CYC + 2);

  cal_state_t       state_q, state_d;
  logic             pend_q;
  logic [TMR_W-1:0] tmr;
  logic             ovr_lvl, ovr_fell, drift_hit;
  logic             start_pulse, release_rst, tmr_clr, ref_capture, any_req;

  adc_cal_sync u_sync (
    .clk, .rst_n, .async_in(adc_ovr), .level(ovr_lvl), .fell(ovr_fell)
  );

  adc_cal_timer #(.W(TMR_W), .LIMIT(CNT_MAX)) u_tmr (
    .clk, .rst_n, .clr(tmr_clr), .count(tmr)
  );

  adc_cal_drift #(.PERIOD_W(PERIOD_W)) u_drift (
    .clk, .rst_n, .capture(ref_capture), .period(clk_period),
    .period_valid, .drift(drift_hit)
  );

  assign any_req = pend_q | cal_req | drift_hit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CAL_IDLE:    if (any_req) state_d = CAL_PULSE;
      CAL_PULSE:   if (tmr == PULSE_LAST) state_d = CAL_ARM;
      CAL_ARM: begin
        if (tmr == WAIT_LAST) state_d = CAL_EXPIRED;
        else if (ovr_lvl)     state_d = CAL_WAIT;
      end
      CAL_WAIT: begin
        if (ovr_fell)         state_d = CAL_OK;
        else if (tmr == WAIT_LAST) state_d = CAL_EXPIRED;
      end
      CAL_OK:      state_d = CAL_IDLE;
      CAL_EXPIRED: state_d = CAL_IDLE;
      default:     state_d = CAL_IDLE;
    endcase
  end

  // Named events: the timer restarts on pulse start and on reset release only
  assign start_pulse = (state_q == CAL_IDLE)  && (state_d == CAL_PULSE);
  assign release_rst = (state_q == CAL_PULSE) && (state_d == CAL_ARM);
  assign tmr_clr     = start_pulse | release_rst;
  assign ref_capture = (state_q == CAL_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CAL_IDLE;
      pend_q      <= 1'b1;
      adc_rst_n   <= 1'b1;
      cal_busy    <= 1'b0;
      cal_done    <= 1'b0;
      cal_timeout <= 1'b0;
    end else begin
      state_q   <= state_d;
      adc_rst_n <= (state_d != CAL_PULSE);
      cal_busy  <= (state_d == CAL_PULSE) || (state_d == CAL_ARM) || (state_d == CAL_WAIT);
      if (start_pulse)                        pend_q <= 1'b0;
      else if (cal_req && state_q != CAL_IDLE) pend_q <= 1'b1;
      if (start_pulse) begin
        cal_done    <= 1'b0;
        cal_timeout <= 1'b0;
      end else begin
        if (state_d == CAL_OK)      cal_done    <= 1'b1;
        if (state_d == CAL_EXPIRED) cal_timeout <= 1'b1;
      end
    end
  end

  assign drift_flag = drift_hit;

  // Checker-only low-time counter for the reset pulse
  logic [LOW_W-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (adc_rst_n)  low_cnt <= '0;
    else                 low_cnt <= low_cnt + 1'b1;
  end

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rst_n) |-> (low_cnt == LOW_W'(RST_PULSE_CYC)));
  p_done_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> $past(ovr_fell));
  p_status_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cal_busy, cal_done, cal_timeout}));
  p_released_while_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAL_WAIT) |-> adc_rst_n);
  p_idle_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CAL_IDLE && cal_req) |=> !adc_rst_n);
  p_pending_replay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == CAL_OK || state_q == CAL_EXPIRED) && pend_q) |=> ##1 !adc_rst_n);
endmodule

// File: tb/test_adc_cal_sequencer.sv
`timescale 1ns/1ps
module test_adc_cal_sequencer;
  localparam int PW     = 16;
  localparam int PULSE  = 4;
  localparam int TMO    = 300;
  localparam int CALLEN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_req = 1'b0;
  logic [PW-1:0] clk_period = 16'd1000;
  logic period_valid = 1'b1;
  logic adc_ovr = 1'b0;
  logic adc_rst_n, cal_busy, cal_done, cal_timeout, drift_flag;

  int checks = 0;
  int errors = 0;
  logic stuck = 1'b0;

  always #2.5 clk = ~clk;

  adc_cal_sequencer #(.PERIOD_W(PW), .RST_PULSE_CYC(PULSE), .TIMEOUT_CYC(TMO)) i_adc_cal_sequencer (
    .clk, .rst_n, .cal_req, .clk_period, .period_valid, .adc_ovr,
    .adc_rst_n, .cal_busy, .cal_done, .cal_timeout, .drift_flag
  );

  // Converter model: flag high while reset low, falls CALLEN cycles after release
  int  mcnt = 0;
  logic mrun = 1'b0;
  always @(negedge clk) begin
    if (!adc_rst_n) begin
      adc_ovr <= 1'b1; mrun <= 1'b1; mcnt <= 0;
    end else if (mrun) begin
      if (mcnt == CALLEN - 1 && !stuck) begin adc_ovr <= 1'b0; mrun <= 1'b0; end
      else if (mcnt < CALLEN - 1) mcnt <= mcnt + 1;
    end
  end

  // Pulse monitor
  int pulses = 0, lowc = 0, last_w = 0;
  logic prev_rn = 1'b1;
  always @(negedge clk) begin
    prev_rn <= adc_rst_n;
    if (!adc_rst_n) lowc <= lowc + 1;
    else if (!prev_rn) begin pulses <= pulses + 1; last_w <= lowc; lowc <= 0; end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_req();
    cal_req = 1'b1; @(negedge clk); cal_req = 1'b0;
  endtask

  task automatic t_reset();
    ticks(3);
    check("R1 adc_rst_n in reset", adc_rst_n, 1);
    check("R1 busy in reset", cal_busy, 0);
    check("R1 done in reset", cal_done, 0);
    check("R1 timeout in reset", cal_timeout, 0);
  endtask

  task automatic t_powerup();
    rst_n = 1'b1;
    ticks(3);
    check("R2 auto pulse after reset", adc_rst_n, 0);
    check("R4 busy during pulse", cal_busy, 1);
    ticks(120);
    check("R2 single power-up pulse", pulses, 1);
    check("R3 pulse width", last_w, PULSE);
    check("R4 done after power-up", cal_done, 1);
    check("R4 busy cleared", cal_busy, 0);
    check("R9 no drift at reference", drift_flag, 0);
  endtask

  task automatic t_request();
    int n;
    pulse_req();
    check("R6 request starts pulse", adc_rst_n, 0);
    check("R6 done cleared at start", cal_done, 0);
    n = 0;
    while (adc_ovr !== 1'b0 || adc_rst_n !== 1'b1 || n < 5) begin @(negedge clk); n++; end
    check("R4 not done on flag drop", cal_done, 0);
    @(negedge clk);
    check("R4 not done before sync", cal_done, 0);
    @(negedge clk);
    check("R4 done three edges after drop", cal_done, 1);
    check("R3 pulse width on request", last_w, PULSE);
  endtask

  task automatic t_pending();
    int p0;
    ticks(5);
    p0 = pulses;
    pulse_req();
    ticks(15);
    pulse_req();
    ticks(3);
    pulse_req();
    ticks(200);
    check("R7 merged requests give one extra", pulses - p0, 2);
    check("R7 done after replay", cal_done, 1);
  endtask

  task automatic t_drift();
    int p0;
    p0 = pulses;
    clk_period = 16'd1100;
    ticks(10);
    check("R9 exactly +10% no drift", drift_flag, 0);
    check("R9 exactly +10% no pulse", pulses - p0, 0);
    clk_period = 16'd1101;
    @(negedge clk);
    check("R9 +10%+1 drift", drift_flag, 1);
    ticks(150);
    check("R10 drift starts recal", pulses - p0, 1);
    check("R8 reference updated on done", drift_flag, 0);
    clk_period = 16'd991;
    ticks(5);
    check("R9 exactly -10% no drift", drift_flag, 0);
    clk_period = 16'd990;
    @(negedge clk);
    check("R9 -10%-1 drift", drift_flag, 1);
    ticks(150);
    check("R10 second drift recal", pulses - p0, 2);
  endtask

  task automatic t_timeout();
    int n, p0;
    stuck = 1'b1;
    pulse_req();
    while (adc_rst_n !== 1'b1) @(negedge clk);
    n = 0;
    clk_period = 16'd1050;
    while (cal_timeout !== 1'b1 && n < TMO + 20) begin @(negedge clk); n++; end
    check("R5 timeout window", n, TMO);
    check("R5 busy dropped", cal_busy, 0);
    check("R5 done not set", cal_done, 0);
    stuck = 1'b0;
    ticks(5);
    p0 = pulses;
    clk_period = 16'd1090;
    @(negedge clk);
    check("R8 reference kept after timeout", drift_flag, 1);
    ticks(150);
    check("R10 recal after timeout drift", pulses - p0, 1);
    check("R6 timeout cleared by new cal", cal_timeout, 0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_request();
    t_pending();
    t_drift();
    t_timeout();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end
endmodule